// File: doc/BRIEF.md
# Rotating Priority Interrupt Arbiter

This block collects eight interrupt request lines and decides which one the processor should service next. Each line is captured into a request register, either on a rising edge or as a level, according to a per-line trigger select. A mask register hides lines from arbitration without discarding their requests. An in-service register records the interrupts that have been acknowledged and not yet ended, so that a new request interrupts the processor only when it outranks all of the work already in progress.

Priority is measured against a rotating base offset. The base can be loaded directly. It can also advance automatically after an end of interrupt, or after an acknowledge when automatic end of interrupt is on, so that the line just served drops to the lowest rank. The processor pulses an acknowledge strobe to accept the current winner and pulses an end-of-interrupt strobe to retire the highest-ranked in-service line. A nesting option for a master unit makes the cascade line's in-service bit invisible to the comparison. That lets a second request arriving through the cascade line get through.

Top module: `rot_irq_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the request, mask and in-service registers read 0x00, the base offset reads 0, and irq_out and win_idx are 0.
- R2: For a line with trig_level low (edge), the request bit is set in the cycle after req_in rises from a sampled low to high. It stays set when req_in falls and is cleared only by an acknowledge of that line.
- R3: For a line with trig_level high (level), the request bit equals the req_in value sampled at the previous clock edge.
- R4: A pulse on mask_wr loads mask_data into the mask register. A masked line (mask bit 1) keeps its request bit visible but takes no part in arbitration.
- R5: The rank of line n is (n - base) mod 8, and rank 0 is the highest. The winner is the unmasked pending line with the lowest rank. A pulse on base_wr loads base_data into the base offset.
- R6: irq_out and win_idx are registered. They show, one clock after the state they depend on, whether the best pending rank is strictly lower than the best in-service rank (an empty in-service set counts as rank 8) and, if so, the winning line number. When irq_out is low, win_idx is 0.
- R7: An ack pulse while a winner exists sets that line's in-service bit. It clears the line's request bit only if the line is edge-triggered. An ack with no winner changes nothing.
- R8: With auto_eoi_en high, an acknowledge leaves the in-service register unchanged and still clears an edge request. If aeoi_rotate is also high, the base becomes (line + 1) mod 8.
- R9: An eoi pulse clears the in-service bit of lowest rank. If eoi_rotate is also high, the base becomes (that line + 1) mod 8.
- R10: With nested_en and is_master both high, in-service bit 2 is ignored when the best in-service rank is computed. Otherwise it counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per-line trigger select: 1 level, 0 rising edge |
| mask_wr | input | 1 | Load strobe for the mask register |
| mask_data | input | 8 | New mask value, 1 masks the line |
| base_wr | input | 1 | Load strobe for the base offset |
| base_data | input | 3 | New base offset |
| ack | input | 1 | Acknowledge strobe for the current winner |
| eoi | input | 1 | End-of-interrupt strobe, retires the lowest-rank in-service line |
| eoi_rotate | input | 1 | With eoi, move the base past the retired line |
| auto_eoi_en | input | 1 | Automatic end of interrupt at acknowledge |
| aeoi_rotate | input | 1 | With automatic end of interrupt, move the base past the acknowledged line |
| nested_en | input | 1 | Nesting option that hides in-service bit 2 |
| is_master | input | 1 | Marks this unit as the master of a cascade |
| irq_out | output | 1 | Registered interrupt request to the processor |
| win_idx | output | 3 | Registered winning line number |
| irr_out | output | 8 | Request register |
| imr_out | output | 8 | Mask register |
| isr_out | output | 8 | In-service register |
| base_out | output | 3 | Current base offset |

## Verification
The arbitration is driven with level requests over many combinations of base and mask. The cases include several lines pending at once on both sides of the base, a masked line that would otherwise win, and an all-masked word, which tell a correct modular rank apart from a plain lowest-index search. Edge lines are tried with held, released and nested requests. These separate capture on a rising edge from following the level, and show that a lower-ranked request is held off by an in-service line while a higher-ranked one gets through. Equal rank between pending and in-service on a level line checks the strict comparison. Automatic end of interrupt, end of interrupt with rotation, and the nesting option with and without master status check the in-service bookkeeping and base movement.

// File: rtl/rot_irq_pkg.sv
package rot_irq_pkg;
  localparam int unsigned LINES        = 8;
  localparam int unsigned CASCADE_LINE = 2;
endpackage

// File: rtl/rot_irq_prio.sv
// Finds the set bit of lowest rank, where rank = (bit - base) mod N.
module rot_irq_prio #(
  parameter int unsigned N     = 8,
  localparam int unsigned IW   = $clog2(N),
  localparam int unsigned RW   = IW + 1
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] base,
  output logic [RW-1:0] rank,
  output logic [IW-1:0] line,
  output logic          any
);
  logic [IW-1:0] probe;

  always_comb begin
    rank  = RW'(N);
    line  = '0;
    any   = 1'b0;
    probe = '0;
    for (int i = 0; i < N; i++) begin
      probe = base + IW'(i);
      if (!any && vec[probe]) begin
        any  = 1'b1;
        rank = RW'(i);
        line = probe;
      end
    end
  end
endmodule

// File: rtl/rot_irq_capture.sv
// Request register with per-line edge or level capture.
module rot_irq_capture #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_in,
  input  logic [N-1:0] trig_level,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr_q
);
  logic [N-1:0] last_q;
  logic [N-1:0] rise;
  logic [N-1:0] irr_d;

  always_comb begin
    rise  = req_in & ~last_q;
    irr_d = (trig_level & req_in) | (~trig_level & (irr_q | rise) & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      last_q <= '0;
    end else begin
      irr_q  <= irr_d;
      last_q <= req_in;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r2_edge_sets : assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[g] && req_in[g] && !last_q[g] && !clr[g]) |=> irr_q[g]);
    a_r2_edge_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_level[g] && irr_q[g] && !clr[g]) |=> irr_q[g]);
    a_r3_level_follows : assert property (@(posedge clk) disable iff (!rst_n)
      trig_level[g] |=> (irr_q[g] == $past(req_in[g])));
  end
endmodule

// File: rtl/rot_irq_arbiter.sv
module rot_irq_arbiter
  import rot_irq_pkg::*;
#(
  parameter int unsigned N    = LINES,
  parameter int unsigned CASC = CASCADE_LINE,
  localparam int unsigned IW  = $clog2(N),
  localparam int unsigned RW  = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_in,
  input  logic [N-1:0]  trig_level,
  input  logic          mask_wr,
  input  logic [N-1:0]  mask_data,
  input  logic          base_wr,
  input  logic [IW-1:0] base_data,
  input  logic          ack,
  input  logic          eoi,
  input  logic          eoi_rotate,
  input  logic          auto_eoi_en,
  input  logic          aeoi_rotate,
  input  logic          nested_en,
  input  logic          is_master,
  output logic          irq_out,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  irr_out,
  output logic [N-1:0]  imr_out,
  output logic [N-1:0]  isr_out,
  output logic [IW-1:0] base_out
);
  localparam logic [N-1:0] CASC_BIT = N'(1) << CASC;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic [N-1:0]  irr_q, imr_q, isr_q;
  logic [IW-1:0] base_q;
  logic          irq_q;
  logic [IW-1:0] idx_q;

  logic [N-1:0]  pend, isr_cmp, take_oh, eoi_oh;
  logic [RW-1:0] pend_rank, cmp_rank, eoi_rank;
  logic [IW-1:0] pend_line, cmp_line, eoi_line;
  logic          pend_any, cmp_any, eoi_any;
  logic          win_valid, take, retire;

  assign pend    = irr_q & ~imr_q;
  assign isr_cmp = (nested_en && is_master) ? (isr_q & ~CASC_BIT) : isr_q;

  rot_irq_prio #(.N(N)) u_pend (
    .vec(pend), .base(base_q), .rank(pend_rank), .line(pend_line), .any(pend_any));
  rot_irq_prio #(.N(N)) u_cmp (
    .vec(isr_cmp), .base(base_q), .rank(cmp_rank), .line(cmp_line), .any(cmp_any));
  rot_irq_prio #(.N(N)) u_eoi (
    .vec(isr_q), .base(base_q), .rank(eoi_rank), .line(eoi_line), .any(eoi_any));

  assign win_valid = pend_any && (pend_rank < cmp_rank);
  assign take      = ack && win_valid;
  assign retire    = eoi && eoi_any;
  assign take_oh   = take   ? (N'(1) << pend_line) : '0;
  assign eoi_oh    = retire ? (N'(1) << eoi_line)  : '0;

  rot_irq_capture #(.N(N)) u_cap (
    .clk(clk), .rst_n(rst_s), .req_in(req_in), .trig_level(trig_level),
    .clr(take_oh), .irr_q(irr_q));

  // next state
  logic [N-1:0]  imr_d, isr_d;
  logic [IW-1:0] base_d;
  logic          imr_en, isr_en, base_en;
  logic          irq_d;
  logic [IW-1:0] idx_d;

  always_comb begin
    imr_en  = mask_wr;
    imr_d   = mask_data;
    isr_en  = retire || (take && !auto_eoi_en);
    isr_d   = (isr_q & ~eoi_oh) | (auto_eoi_en ? '0 : take_oh);
    base_en = 1'b1;
    if (base_wr)                               base_d = base_data;
    else if (retire && eoi_rotate)             base_d = eoi_line + IW'(1);
    else if (take && auto_eoi_en && aeoi_rotate) base_d = pend_line + IW'(1);
    else begin
      base_d  = base_q;
      base_en = 1'b0;
    end
    irq_d = win_valid;
    idx_d = win_valid ? pend_line : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      imr_q  <= '0;
      isr_q  <= '0;
      base_q <= '0;
      irq_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      if (imr_en)  imr_q  <= imr_d;
      if (isr_en)  isr_q  <= isr_d;
      if (base_en) base_q <= base_d;
      irq_q <= irq_d;
      idx_q <= idx_d;
    end
  end

  assign irq_out  = irq_q;
  assign win_idx  = idx_q;
  assign irr_out  = irr_q;
  assign imr_out  = imr_q;
  assign isr_out  = isr_q;
  assign base_out = base_q;

  a_r6_irq_needs_pending : assert property (@(posedge clk) disable iff (!rst_s)
    irq_q |-> $past(pend_any));
  a_r7_ack_sets_isr : assert property (@(posedge clk) disable iff (!rst_s)
    (take && !auto_eoi_en) |=> isr_q[$past(pend_line)]);
  a_r8_aeoi_keeps_isr : assert property (@(posedge clk) disable iff (!rst_s)
    (take && auto_eoi_en && !eoi) |=> $stable(isr_q));
  a_r9_eoi_retires_one : assert property (@(posedge clk) disable iff (!rst_s)
    (retire && !take) |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  a_r10_nested_hides : assert property (@(posedge clk) disable iff (!rst_s)
    (nested_en && is_master && isr_q == CASC_BIT) |-> !cmp_any);
endmodule

// File: tb/test_rot_irq_arbiter.sv
`timescale 1ns/1ps
module test_rot_irq_arbiter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_in, trig_level, mask_data;
  logic       mask_wr, base_wr, ack, eoi, eoi_rotate;
  logic       auto_eoi_en, aeoi_rotate, nested_en, is_master;
  logic [2:0] base_data;
  logic       irq_out;
  logic [2:0] win_idx, base_out;
  logic [7:0] irr_out, imr_out, isr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  rot_irq_arbiter i_rot_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level),
    .mask_wr(mask_wr), .mask_data(mask_data), .base_wr(base_wr),
    .base_data(base_data), .ack(ack), .eoi(eoi), .eoi_rotate(eoi_rotate),
    .auto_eoi_en(auto_eoi_en), .aeoi_rotate(aeoi_rotate),
    .nested_en(nested_en), .is_master(is_master), .irq_out(irq_out),
    .win_idx(win_idx), .irr_out(irr_out), .imr_out(imr_out),
    .isr_out(isr_out), .base_out(base_out));

  // fields: base(3) mask(8) req(8) irq(1) idx(3)
  localparam logic [22:0] VEC [9] = '{
    {3'd0, 8'h00, 8'h00, 1'b0, 3'd0},
    {3'd0, 8'h00, 8'hA0, 1'b1, 3'd5},
    {3'd0, 8'h20, 8'hA0, 1'b1, 3'd7},
    {3'd6, 8'h00, 8'h21, 1'b1, 3'd0},
    {3'd6, 8'h00, 8'h60, 1'b1, 3'd6},
    {3'd3, 8'h00, 8'h05, 1'b1, 3'd0},
    {3'd3, 8'hFF, 8'hFF, 1'b0, 3'd0},
    {3'd7, 8'h80, 8'h81, 1'b1, 3'd0},
    {3'd1, 8'h00, 8'h81, 1'b1, 3'd7}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_in = '0; trig_level = '0; mask_data = '0; base_data = '0;
    mask_wr = 0; base_wr = 0; ack = 0; eoi = 0; eoi_rotate = 0;
    auto_eoi_en = 0; aeoi_rotate = 0; nested_en = 0; is_master = 0;
    #20;
    rst_n = 1'b1;
    tick(); tick(); tick();
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_eoi(input logic rot);
    eoi = 1'b1; eoi_rotate = rot; tick(); eoi = 1'b0; eoi_rotate = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state while held
    rst_n = 1'b0;
    req_in = '0; trig_level = '0; mask_data = '0; base_data = '0;
    mask_wr = 0; base_wr = 0; ack = 0; eoi = 0; eoi_rotate = 0;
    auto_eoi_en = 0; aeoi_rotate = 0; nested_en = 0; is_master = 0;
    #20;
    chk("R1 irr", irr_out, 8'h00);
    chk("R1 imr", imr_out, 8'h00);
    chk("R1 isr", isr_out, 8'h00);
    chk("R1 base", {5'd0, base_out}, 8'd0);
    chk("R1 irq", {7'd0, irq_out}, 8'd0);
    do_reset();

    // table walk: level lines, R3 R4 R5 R6
    for (int v = 0; v < 9; v++) begin
      trig_level = 8'hFF;
      base_wr = 1'b1; base_data = VEC[v][22:20];
      mask_wr = 1'b1; mask_data = VEC[v][19:12];
      req_in  = VEC[v][11:4];
      tick();
      base_wr = 1'b0; mask_wr = 1'b0;
      chk("R3 level irr", irr_out, VEC[v][11:4]);
      chk("R4 mask load", imr_out, VEC[v][19:12]);
      chk("R5 base load", {5'd0, base_out}, {5'd0, VEC[v][22:20]});
      tick();
      chk("R6 irq", {7'd0, irq_out}, {7'd0, VEC[v][3]});
      chk("R5 winner", {5'd0, win_idx}, {5'd0, VEC[v][2:0]});
    end

    // edge capture, nesting, end of interrupt
    do_reset();
    req_in = 8'h08; tick();
    chk("R2 edge set", irr_out, 8'h08);
    tick();
    chk("R6 irq edge", {4'd0, irq_out, win_idx}, {4'd0, 1'b1, 3'd3});
    req_in = 8'h00; tick();
    chk("R2 edge held", irr_out, 8'h08);
    pulse_ack();
    chk("R7 isr set", isr_out, 8'h08);
    chk("R7 edge cleared", irr_out, 8'h00);
    tick();
    chk("R6 irq drops", {7'd0, irq_out}, 8'd0);
    req_in = 8'h20; tick();
    chk("R2 line5", irr_out, 8'h20);
    tick();
    chk("R6 lower held off", {7'd0, irq_out}, 8'd0);
    req_in = 8'h22; tick(); tick();
    chk("R6 higher nests", {4'd0, irq_out, win_idx}, {4'd0, 1'b1, 3'd1});
    pulse_ack();
    chk("R7 nested isr", isr_out, 8'h0A);
    chk("R7 nested irr", irr_out, 8'h20);
    pulse_eoi(1'b0);
    chk("R9 eoi top", isr_out, 8'h08);
    tick();
    chk("R9 still held", {7'd0, irq_out}, 8'd0);
    pulse_eoi(1'b0);
    chk("R9 eoi empty", isr_out, 8'h00);
    tick();
    chk("R9 line5 out", {4'd0, irq_out, win_idx}, {4'd0, 1'b1, 3'd5});
    pulse_ack();
    chk("R7 isr line5", isr_out, 8'h20);
    pulse_eoi(1'b1);
    chk("R9 rot isr", isr_out, 8'h00);
    chk("R9 rot base", {5'd0, base_out}, 8'd6);

    // level acknowledge and strict comparison, after reset (R1)
    do_reset();
    chk("R1 base after reset", {5'd0, base_out}, 8'd0);
    chk("R1 isr after reset", isr_out, 8'h00);
    trig_level = 8'h10; req_in = 8'h10; tick();
    pulse_ack();
    chk("R7 level isr", isr_out, 8'h10);
    chk("R7 level irr kept", irr_out, 8'h10);
    tick();
    chk("R6 equal rank", {7'd0, irq_out}, 8'd0);

    // acknowledge without a winner
    do_reset();
    pulse_ack();
    chk("R7 idle ack isr", isr_out, 8'h00);
    chk("R7 idle ack base", {5'd0, base_out}, 8'd0);

    // automatic end of interrupt with rotation
    do_reset();
    auto_eoi_en = 1'b1; aeoi_rotate = 1'b1;
    req_in = 8'h04; tick();
    pulse_ack();
    chk("R8 isr untouched", isr_out, 8'h00);
    chk("R8 irr cleared", irr_out, 8'h00);
    chk("R8 base rotated", {5'd0, base_out}, 8'd3);
    auto_eoi_en = 1'b0; aeoi_rotate = 1'b0;

    // nesting option on cascade line
    do_reset();
    nested_en = 1'b1; is_master = 1'b1;
    trig_level = 8'h04; req_in = 8'h04; tick();
    pulse_ack();
    chk("R10 isr", isr_out, 8'h04);
    tick();
    chk("R10 master hides", {4'd0, irq_out, win_idx}, {4'd0, 1'b1, 3'd2});
    is_master = 1'b0; tick();
    chk("R10 not master", {7'd0, irq_out}, 8'd0);
    is_master = 1'b1; nested_en = 1'b0; tick();
    chk("R10 option off", {7'd0, irq_out}, 8'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule